// File: doc/BRIEF.md
# Segmented Pretrigger Capture Buffer

This block is the sample store of an on-chip logic analyzer. On every clock where the sample enable is high it records one packed probe word. The store has a power-of-two depth fixed at build time. When the block is armed, the store is divided into a power-of-two number of equal windows, and each window is filled around one trigger event. Software sets the window count and a trigger position before it arms the block. The trigger position is the number of samples kept from before the trigger.

While a window waits for its trigger, it is written as a ring. An accepted trigger fixes the trigger sample's slot in that window. After the trigger, the block stores only enough further samples to complete the window, and then it moves on to the next window. The trigger slot of each window is held so that the host can rotate the window contents into time order. A per-slot valid bit marks the pretrigger slots that were never written because the trigger came early. When the last window is complete, the block raises done. An abort drops the capture and leaves no valid data.

Top module: `seg_capture_buffer`

## Requirements
- R1: After reset, `done` is low and `rd_valid` is low for every address.
- R2: When armed, the block uses a window count of 2^E, where E is `win_log2` clamped to MAXWIN_LOG2. The window depth is 2^(DEPTH_LOG2−E). Window w covers addresses w·depth to (w+1)·depth−1.
- R3: Samples are written into a window at offsets 0, 1, 2 and onward, wrapping at the window depth. `rd_trig_off` for window `rd_win` gives the offset of that window's trigger sample. The sample taken d enabled cycles after the trigger sits at offset (trigger offset + d) mod depth, for d from −P to depth−P−1, where P is the effective trigger position.
- R4: The effective trigger position P is `trig_pos` masked to the bits below the window depth (`trig_pos` mod depth). When P = depth−1, the trigger sample is the last sample of the window, and the window is complete on the trigger cycle.
- R5: After the trigger, the window takes exactly depth−P samples counting the trigger sample, and then capture moves to the next window at offset 0. Trigger pulses that arrive during this post-trigger fill have no effect.
- R6: A trigger is accepted even when fewer than P samples precede it in the window. If k samples precede it, the P−k oldest pretrigger slots read `rd_valid` = 0.
- R7: When `trig_enable` is low, every enabled sample in a waiting window is treated as the trigger sample.
- R8: A cycle with `sample_en` low writes nothing, advances nothing, and is not taken as a trigger, even if `trig` is high.
- R9: `done` rises on the clock edge that stores the last sample of the last window. `start` clears `done` and all valid bits and begins capture in window 0.
- R10: `abort` returns the block to idle, with `done` low and every valid bit clear. Enabled samples that follow are not recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Arm pulse; latches settings and clears the store |
| abort | input | 1 | Cancels capture; priority over start |
| sample_en | input | 1 | Qualifies the probe word on this cycle |
| probe | input | DATA_W | Probe word to record |
| trig | input | 1 | One-cycle trigger pulse |
| trig_enable | input | 1 | 0: trigger immediately on each window's first sample |
| win_log2 | input | $clog2(MAXWIN_LOG2+1) | log2 of the requested window count |
| trig_pos | input | DEPTH_LOG2 | Pretrigger sample count |
| done | output | 1 | All windows full |
| rd_addr | input | DEPTH_LOG2 | Read address into the store |
| rd_data | output | DATA_W | Word at rd_addr |
| rd_valid | output | 1 | Word at rd_addr was written in this capture |
| rd_win | input | MAXWIN_LOG2 | Window index for the trigger-offset read |
| rd_trig_off | output | DEPTH_LOG2 | Trigger slot offset within window rd_win |

## Verification
The embedded assertions check several properties on every cycle. The write offset stays inside the current window. The post-trigger countdown stays inside its range. `done` only rises on a cycle that wrote a sample, and abort or start leaves the valid bits clear. Only the bench's scenarios can show whether each window holds the right samples in the right slots. They cover the trigger offsets, the mod-depth position masking, the window-count clamp, the invalid slots left by an early trigger, the ignored triggers during gaps and post-trigger fill, and immediate capture with triggers disabled. They do this by replaying known probe sequences and reading back the whole store.

// File: rtl/cap_pkg.sv
package cap_pkg;

  typedef enum logic [1:0] {
    CS_IDLE = 2'd0,
    CS_PRE  = 2'd1,
    CS_POST = 2'd2,
    CS_DONE = 2'd3
  } cap_state_e;

  // Requested window-count exponent limited to the build maximum.
  function automatic int unsigned eff_win_log2(int unsigned wl, int unsigned max_log2);
    return (wl > max_log2) ? max_log2 : wl;
  endfunction

  // Samples per window for a given store size and window exponent.
  function automatic int unsigned win_depth(int unsigned depth_log2, int unsigned eff);
    return 32'd1 << (depth_log2 - eff);
  endfunction

  // Ring advance inside one window.
  function automatic int unsigned next_off(int unsigned off, int unsigned wd);
    return (off + 1 == wd) ? 0 : off + 1;
  endfunction

endpackage

// File: rtl/cap_window_ctrl.sv
module cap_window_ctrl
  import cap_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int MAXWIN_LOG2 = 4,
  parameter int WL_W        = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic                   abort_i,
  input  logic                   sample_en_i,
  input  logic                   trig_i,
  input  logic                   trig_enable_i,
  input  logic [WL_W-1:0]        win_log2_i,
  input  logic [ADDR_W-1:0]      trig_pos_i,
  output logic                   wr_en_o,
  output logic [ADDR_W-1:0]      wr_addr_o,
  output logic                   trig_we_o,
  output logic [MAXWIN_LOG2-1:0] trig_win_o,
  output logic [ADDR_W-1:0]      trig_off_o,
  output logic                   clear_o,
  output logic                   done_o
);

  localparam int CNT_W = ADDR_W + 1;

  cap_state_e             state_q;
  logic [CNT_W-1:0]       wd_q;
  logic [CNT_W-1:0]       post_q;
  logic [ADDR_W-1:0]      pos_q;
  logic [ADDR_W-1:0]      off_q;
  logic [MAXWIN_LOG2-1:0] win_q;
  logic [MAXWIN_LOG2-1:0] last_win_q;

  // Settings derived at arm time.
  int unsigned eff_s, wd_s, pos_s;
  always_comb begin
    eff_s = eff_win_log2(32'(win_log2_i), MAXWIN_LOG2);
    wd_s  = win_depth(ADDR_W, eff_s);
    pos_s = 32'(trig_pos_i) & (wd_s - 1);
  end

  // Named internal events.
  logic                capturing, samp, trig_hit, last_post, win_end;
  logic [CNT_W-1:0]    rem;
  logic [CNT_W-1:0]    base_full;
  logic [ADDR_W-1:0]   off_next;

  assign capturing = (state_q == CS_PRE) || (state_q == CS_POST);
  assign samp      = capturing && sample_en_i && !start_i && !abort_i;
  assign trig_hit  = samp && (state_q == CS_PRE) && (trig_i || !trig_enable_i);
  assign rem       = wd_q - CNT_W'(1) - CNT_W'(pos_q);
  assign last_post = samp && (state_q == CS_POST) && (post_q == CNT_W'(1));
  assign win_end   = (trig_hit && (rem == '0)) || last_post;
  assign base_full = CNT_W'(win_q) * wd_q;
  assign off_next  = ADDR_W'(next_off(32'(off_q), 32'(wd_q)));

  assign wr_en_o    = samp;
  assign wr_addr_o  = ADDR_W'(base_full) + off_q;
  assign trig_we_o  = trig_hit;
  assign trig_win_o = win_q;
  assign trig_off_o = off_q;
  assign clear_o    = start_i || abort_i;
  assign done_o     = (state_q == CS_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= CS_IDLE;
      wd_q       <= '0;
      post_q     <= '0;
      pos_q      <= '0;
      off_q      <= '0;
      win_q      <= '0;
      last_win_q <= '0;
    end else if (abort_i) begin
      state_q <= CS_IDLE;
    end else if (start_i) begin
      state_q    <= CS_PRE;
      wd_q       <= CNT_W'(wd_s);
      pos_q      <= ADDR_W'(pos_s);
      off_q      <= '0;
      win_q      <= '0;
      post_q     <= '0;
      last_win_q <= MAXWIN_LOG2'((32'd1 << eff_s) - 1);
    end else if (samp) begin
      if (win_end) begin
        off_q  <= '0;
        post_q <= '0;
        if (win_q == last_win_q) begin
          state_q <= CS_DONE;
        end else begin
          win_q   <= win_q + 1'b1;
          state_q <= CS_PRE;
        end
      end else begin
        off_q <= off_next;
        if (trig_hit) begin
          state_q <= CS_POST;
          post_q  <= rem;
        end else if (state_q == CS_POST) begin
          post_q <= post_q - CNT_W'(1);
        end
      end
    end
  end

  assert_offset_in_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    capturing |-> (CNT_W'(off_q) < wd_q));

  assert_post_count_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CS_POST) |-> ((post_q != '0) && (post_q < wd_q)));

  assert_done_on_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(wr_en_o));

  assert_abort_idles_R10: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (!done_o && !wr_en_o));

endmodule

// File: rtl/cap_sample_store.sv
module cap_sample_store #(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 5,
  parameter int MAXWIN_LOG2 = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear_i,
  input  logic                   wr_en_i,
  input  logic [ADDR_W-1:0]      wr_addr_i,
  input  logic [DATA_W-1:0]      wr_data_i,
  input  logic                   trig_we_i,
  input  logic [MAXWIN_LOG2-1:0] trig_win_i,
  input  logic [ADDR_W-1:0]      trig_off_i,
  input  logic [ADDR_W-1:0]      rd_addr_i,
  output logic [DATA_W-1:0]      rd_data_o,
  output logic                   rd_valid_o,
  input  logic [MAXWIN_LOG2-1:0] rd_win_i,
  output logic [ADDR_W-1:0]      rd_trig_off_o
);

  localparam int DEPTH   = 1 << ADDR_W;
  localparam int MAX_WIN = 1 << MAXWIN_LOG2;

  logic [DATA_W-1:0] mem_q  [DEPTH];
  logic [ADDR_W-1:0] toff_q [MAX_WIN];
  logic [DEPTH-1:0]  valid_q;

  always_ff @(posedge clk) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
    if (trig_we_i) toff_q[trig_win_i] <= trig_off_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) valid_q <= '0;
    else if (wr_en_i) valid_q[wr_addr_i] <= 1'b1;
  end

  assign rd_data_o     = mem_q[rd_addr_i];
  assign rd_valid_o    = valid_q[rd_addr_i];
  assign rd_trig_off_o = toff_q[rd_win_i];

  assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (valid_q == '0));

  assert_trig_writes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trig_we_i |-> wr_en_i);

endmodule

// File: rtl/seg_capture_buffer.sv
module seg_capture_buffer #(
  parameter int DATA_W      = 8,
  parameter int DEPTH_LOG2  = 5,
  parameter int MAXWIN_LOG2 = 4,
  localparam int WL_W       = $clog2(MAXWIN_LOG2 + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   abort,
  input  logic                   sample_en,
  input  logic [DATA_W-1:0]      probe,
  input  logic                   trig,
  input  logic                   trig_enable,
  input  logic [WL_W-1:0]        win_log2,
  input  logic [DEPTH_LOG2-1:0]  trig_pos,
  output logic                   done,
  input  logic [DEPTH_LOG2-1:0]  rd_addr,
  output logic [DATA_W-1:0]      rd_data,
  output logic                   rd_valid,
  input  logic [MAXWIN_LOG2-1:0] rd_win,
  output logic [DEPTH_LOG2-1:0]  rd_trig_off
);

  logic                   wr_en, trig_we, clear;
  logic [DEPTH_LOG2-1:0]  wr_addr, trig_off;
  logic [MAXWIN_LOG2-1:0] trig_win;

  cap_window_ctrl #(
    .ADDR_W(DEPTH_LOG2), .MAXWIN_LOG2(MAXWIN_LOG2), .WL_W(WL_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start), .abort_i(abort),
    .sample_en_i(sample_en), .trig_i(trig), .trig_enable_i(trig_enable),
    .win_log2_i(win_log2), .trig_pos_i(trig_pos),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .trig_we_o(trig_we),
    .trig_win_o(trig_win), .trig_off_o(trig_off), .clear_o(clear),
    .done_o(done)
  );

  cap_sample_store #(
    .DATA_W(DATA_W), .ADDR_W(DEPTH_LOG2), .MAXWIN_LOG2(MAXWIN_LOG2)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .clear_i(clear), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(probe), .trig_we_i(trig_we),
    .trig_win_i(trig_win), .trig_off_i(trig_off), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid), .rd_win_i(rd_win),
    .rd_trig_off_o(rd_trig_off)
  );

endmodule

// File: tb/test_seg_capture_buffer.sv
module test_seg_capture_buffer;

  localparam int CLK_PERIOD  = 10;
  localparam int DATA_W      = 8;
  localparam int DEPTH_LOG2  = 5;
  localparam int MAXWIN_LOG2 = 4;
  localparam int DEPTH       = 1 << DEPTH_LOG2;
  localparam int NROWS       = 7;

  // Scenario table: window exponent, trigger position, pretrigger samples,
  // idle gaps with trig high, trigger enable.
  localparam int T_WL  [NROWS] = '{0, 2, 2, 3, 1, 3, 7};
  localparam int T_POS [NROWS] = '{0, 3, 7, 2, 5, 6, 1};
  localparam int T_K   [NROWS] = '{3, 5, 10, 0, 0, 1, 2};
  localparam int T_GAP [NROWS] = '{0, 1, 0, 0, 0, 1, 0};
  localparam int T_TEN [NROWS] = '{1, 1, 1, 1, 0, 1, 1};

  logic clk = 0, rst_n = 0, start = 0, abort = 0, sample_en = 0, trig = 0, trig_enable = 1;
  logic [2:0] win_log2 = '0;
  logic [DEPTH_LOG2-1:0] trig_pos = '0, rd_addr = '0, rd_trig_off;
  logic [DATA_W-1:0] probe = '0, rd_data;
  logic [MAXWIN_LOG2-1:0] rd_win = '0;
  logic done, rd_valid;

  int checks = 0, errors = 0, n = 0;
  int tw [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_capture_buffer #(.DATA_W(DATA_W), .DEPTH_LOG2(DEPTH_LOG2), .MAXWIN_LOG2(MAXWIN_LOG2))
  i_seg_capture_buffer (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .sample_en(sample_en),
    .probe(probe), .trig(trig), .trig_enable(trig_enable), .win_log2(win_log2),
    .trig_pos(trig_pos), .done(done), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_valid(rd_valid), .rd_win(rd_win), .rd_trig_off(rd_trig_off)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_sample(input bit trg);
    @(negedge clk);
    sample_en = 1; probe = DATA_W'(n); trig = trg;
    @(posedge clk); #1;
    sample_en = 0; trig = 0; n++;
  endtask

  task automatic gap_cycle();   // R8: trig high with sample_en low
    @(negedge clk);
    sample_en = 0; trig = 1;
    @(posedge clk); #1;
    trig = 0;
  endtask

  task automatic arm(input int wl, input int pos, input int ten);
    @(negedge clk);
    win_log2 = 3'(wl); trig_pos = DEPTH_LOG2'(pos); trig_enable = ten[0]; start = 1;
    @(posedge clk); #1;
    start = 0;
  endtask

  task automatic check_all_invalid(input string req);
    for (int a = 0; a < DEPTH; a++) begin
      rd_addr = DEPTH_LOG2'(a); #1;
      chk(rd_valid == 1'b0, req, int'(rd_valid), 0);
    end
  endtask

  task automatic run_row(input int r);
    int eff, wd, nw, p, k, slot;
    eff = (T_WL[r] > MAXWIN_LOG2) ? MAXWIN_LOG2 : T_WL[r];   // R2 clamp
    wd  = DEPTH >> eff;
    nw  = 1 << eff;
    p   = T_POS[r] % wd;                                       // R4 masking
    k   = T_K[r];
    arm(T_WL[r], T_POS[r], T_TEN[r]);
    chk(done == 1'b0, "R9 done cleared by start", int'(done), 0);
    rd_addr = '0; #1;
    chk(rd_valid == 1'b0, "R9 valid cleared by start", int'(rd_valid), 0);
    for (int w = 0; w < nw; w++) begin
      for (int i = 0; i < k; i++) begin
        if (T_GAP[r] != 0) gap_cycle();
        do_sample(1'b0);
      end
      if (T_GAP[r] != 0) gap_cycle();
      tw[w] = n;
      do_sample(T_TEN[r] != 0);
      for (int j = 0; j < wd - p - 1; j++) begin
        if (T_GAP[r] != 0) gap_cycle();
        do_sample(j == 0 && T_TEN[r] != 0);   // R5: ignored trigger in post fill
      end
      if (w < nw - 1) chk(done == 1'b0, "R9 done before last window", int'(done), 0);
    end
    chk(done == 1'b1, "R9 done after last window", int'(done), 1);
    for (int w = 0; w < nw; w++) begin
      rd_win = MAXWIN_LOG2'(w); #1;
      chk(int'(rd_trig_off) == k % wd, "R3 trigger offset", int'(rd_trig_off), k % wd);
      for (int d = -p; d < wd - p; d++) begin
        slot = w * wd + ((k % wd) + d + wd) % wd;
        rd_addr = DEPTH_LOG2'(slot); #1;
        if (d >= -k) begin
          chk(rd_valid == 1'b1, "R6 written slot valid", int'(rd_valid), 1);
          chk(rd_data == DATA_W'(tw[w] + d), "R3 sample placement",
              int'(rd_data), int'(DATA_W'(tw[w] + d)));
        end else begin
          chk(rd_valid == 1'b0, "R6 unfilled slot invalid", int'(rd_valid), 0);
        end
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(done == 1'b0, "R1 done at reset", int'(done), 0);
    check_all_invalid("R1 valid at reset");
    @(negedge clk); rst_n = 1;

    // Table walk: rows cover R2 (incl. clamp), R4 (pos=depth-1, masking),
    // R5, R6 (early trigger), R7 (trig_enable low), R8 (gaps).
    for (int r = 0; r < NROWS; r++) run_row(r);

    // R10: abort mid-capture
    arm(0, 4, 1);
    for (int i = 0; i < 3; i++) do_sample(1'b0);
    @(negedge clk); abort = 1;
    @(posedge clk); #1; abort = 0;
    chk(done == 1'b0, "R10 done after abort", int'(done), 0);
    check_all_invalid("R10 valid after abort");
    for (int i = 0; i < 3; i++) do_sample(1'b1);
    chk(done == 1'b0, "R10 idle stays not done", int'(done), 0);
    check_all_invalid("R10 no recording after abort");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule